// File: doc/BRIEF.md
# EDO DRAM Device Cycle Decoder

This block is a synthesizable, device-side model of a small extended-data-out DRAM. It is placed on the far side of a memory controller under test and behaves as the memory would: it watches the active-low row strobe, column strobe, write enable and output enable together with a multiplexed address bus. It works out what kind of cycle each strobe sequence forms and stores or returns bytes from a scaled-down internal array. The data bus is split into an input byte, an output byte and an output enable, which a wrapper can turn into a tri-state pin.

All strobes, the address and the write data are sampled on a fast clock. Edges are found by comparing two successive samples, so every decision is made from the order in which the sampled strobes change. The model also gives a controller designer a pulse whenever the row strobe is held low for too few samples or is precharged for too few samples. It also shows the cycle type it decoded and the row that the next refresh will use.

Top module: `edo_dram_model`

## Requirements
- R1: Whenever the sampled row and column strobes are both high, the data output is disabled and `cycle_type` returns to 0 (idle).
- R2: A row strobe fall while the column strobe is high latches the row from the low `ROW_BITS` of `addr` and sets `cycle_type` to 3 (row open). The next column strobe fall latches the column from the low `COL_BITS`. Cell index is {row, column}. Address bits above those widths are ignored.
- R3: A row strobe fall while the column strobe is already low is a refresh from the internal counter. `refresh_row` increments by one and wraps at 2^ROW_BITS. `cycle_type` becomes 4, `addr` is ignored and the output stays disabled.
- R4: A column fall with write enable high reads the addressed cell and sets `cycle_type` to 1. It drives `dq_out` at once if output enable is low. Otherwise it starts driving on the later output-enable fall.
- R5: A column fall with write enable already low stores `dq_in` and sets `cycle_type` to 2. The output stays disabled for that access, even with output enable low.
- R6: While the row strobe stays low, each further column fall accesses a new column in the same row. It reports `cycle_type` 5 for a read and 6 for a write.
- R7: After a read, rising of the column strobe alone does not stop the output. The byte stays driven while the row strobe is low.
- R8: Output enable going high disables the output. A write-enable fall after a read also disables it until the next read.
- R9: `timing_viol` pulses for one cycle when the row strobe rises after fewer than `MIN_RAS_LOW` consecutive low samples.
- R10: `timing_viol` pulses for one cycle when the row strobe falls after fewer than `MIN_PRECHARGE` high samples. The first fall after reset is exempt.
- R11: After reset the output is disabled, `cycle_type` is 0, `refresh_row` is 0, `timing_viol` is 0 and every cell reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, much faster than the strobes |
| rst_n | input | 1 | Synchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Multiplexed row/column address |
| dq_in | input | DATA_W | Write data from the controller |
| dq_out | output | DATA_W | Read data towards the controller |
| dq_oe | output | 1 | High while the model drives the data bus |
| cycle_type | output | 3 | Decoded cycle: 0 idle, 1 read, 2 early write, 3 row open, 4 refresh, 5 page read, 6 page write |
| refresh_row | output | ROW_BITS | Row used by the next counter refresh |
| timing_viol | output | 1 | One-cycle pulse on a short row-low or precharge period |

## Verification
The bench aims at the orderings that tell one cycle from another. It checks a column strobe already low at the row fall, which a faulty decoder would take as an access and so write or drive during a refresh. It checks write enable already low at the column fall, where a model that missed it would drive stale data. It checks output enable falling after the column strobe, which a model looking only at the column edge would never serve. It also covers the extended-data-out hold after the column strobe rises: a model that treated that rise as the end of the cycle would float the bus early. Last, it checks timing windows one sample short of their limits and the wrap of the refresh counter. These catch off-by-one counters and a missing exemption for the first row fall after reset.

// File: rtl/edo_pkg.sv
// Package: shared types for the EDO DRAM device model.
// Assumes strobe levels are carried as pin levels (1 = high, inactive).
package edo_pkg;

    typedef enum logic [2:0] {
        CYC_IDLE    = 3'd0,
        CYC_READ    = 3'd1,
        CYC_EWRITE  = 3'd2,
        CYC_ROWOPEN = 3'd3,
        CYC_CBR     = 3'd4,
        CYC_PAGE_RD = 3'd5,
        CYC_PAGE_WR = 3'd6
    } cyc_e;

    typedef struct packed {
        logic ras;
        logic cas;
        logic we;
        logic oe;
    } strobes_t;

endpackage

// File: rtl/edo_strobe_sampler.sv
// Module: edo_strobe_sampler
// Samples the four strobes, the address and write data on the fast clock and
// derives fall/rise events from two successive strobe samples.
// Assumes strobes idle high; both sample stages reset to high so no edge is
// seen right after reset. Address and data share the first sample stage, so
// they line up with the strobe sample that shows an edge.
module edo_strobe_sampler
    import edo_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  strobes_t          pins,
    input  logic [ADDR_W-1:0] addr_pin,
    input  logic [DATA_W-1:0] din_pin,
    output strobes_t          cur,
    output strobes_t          fall,
    output strobes_t          rise,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] din_q
);

    strobes_t prev;

    // Two sample stages for strobes, one for address and data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur    <= '1;
            prev   <= '1;
            addr_q <= '0;
            din_q  <= '0;
        end else begin
            cur    <= pins;
            prev   <= cur;
            addr_q <= addr_pin;
            din_q  <= din_pin;
        end
    end

    // Edge events from the two most recent samples.
    always_comb begin
        fall = prev & ~cur;
        rise = ~prev & cur;
    end

endmodule

// File: rtl/edo_timing_mon.sv
// Module: edo_timing_mon
// Counts consecutive low and high samples of the row strobe and pulses a
// violation when a low period or a precharge period is too short.
// Assumes fall/rise events come from edo_strobe_sampler; the first fall after
// reset is not checked for precharge.
module edo_timing_mon #(
    parameter int MIN_RAS_LOW   = 4,
    parameter int MIN_PRECHARGE = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ras_low,
    input  logic ras_fall,
    input  logic ras_rise,
    output logic viol
);

    localparam int LIMIT = (MIN_RAS_LOW > MIN_PRECHARGE) ? MIN_RAS_LOW : MIN_PRECHARGE;
    localparam int CNT_W = $clog2(LIMIT + 1) + 1;
    localparam logic [CNT_W-1:0] SAT = CNT_W'(LIMIT);

    logic [CNT_W-1:0] low_cnt;
    logic [CNT_W-1:0] high_cnt;
    logic             seen_rise;

    // Saturating sample counters for the low and high phases of the row strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_cnt   <= '0;
            high_cnt  <= '0;
            seen_rise <= 1'b0;
        end else begin
            if (ras_fall)
                low_cnt <= CNT_W'(1);
            else if (ras_low && low_cnt < SAT)
                low_cnt <= low_cnt + 1'b1;
            if (ras_rise) begin
                high_cnt  <= CNT_W'(1);
                seen_rise <= 1'b1;
            end else if (!ras_low && high_cnt < SAT)
                high_cnt <= high_cnt + 1'b1;
        end
    end

    // One-cycle violation pulse evaluated at each row strobe edge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            viol <= 1'b0;
        else
            viol <= (ras_rise && low_cnt < CNT_W'(MIN_RAS_LOW)) ||
                    (ras_fall && seen_rise && high_cnt < CNT_W'(MIN_PRECHARGE));
    end

    // R9/R10: a pulse only ever follows a row strobe edge.
    assert_viol_at_edge_R9: assert property (@(posedge clk) disable iff (!rst_n)
        viol |-> $past(ras_fall || ras_rise));

    // R9: a row-low period that reached the limit never flags on its rise.
    assert_long_low_ok_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ras_rise && low_cnt >= CNT_W'(MIN_RAS_LOW) && !ras_fall) |=> !viol);

endmodule

// File: rtl/edo_cell_array.sv
// Module: edo_cell_array
// Scaled storage array: 2^ROW_BITS rows by 2^COL_BITS columns of DATA_W bits.
// Write is synchronous, read is combinational. Cleared to zero by reset.
module edo_cell_array #(
    parameter int ROW_BITS = 4,
    parameter int COL_BITS = 4,
    parameter int DATA_W   = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ROW_BITS-1:0] wr_row,
    input  logic [COL_BITS-1:0] wr_col,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic [ROW_BITS-1:0] rd_row,
    input  logic [COL_BITS-1:0] rd_col,
    output logic [DATA_W-1:0]   rd_data
);

    localparam int DEPTH = 1 << (ROW_BITS + COL_BITS);

    logic [DATA_W-1:0] cells [DEPTH];

    // Synchronous clear and write of one cell.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++)
                cells[i] <= '0;
        end else if (wr_en) begin
            cells[{wr_row, wr_col}] <= wr_data;
        end
    end

    // Combinational read of the addressed cell.
    assign rd_data = cells[{rd_row, rd_col}];

endmodule

// File: rtl/edo_cycle_ctrl.sv
// Module: edo_cycle_ctrl
// Decodes cycles from sampled strobe events: row latch, refresh from the
// internal counter, column reads and writes, page-mode columns, and the
// output-enable state with extended data-out hold after the column strobe.
// Assumes events come from edo_strobe_sampler; late write is not decoded.
module edo_cycle_ctrl
    import edo_pkg::*;
#(
    parameter int ADDR_W   = 11,
    parameter int ROW_BITS = 4,
    parameter int COL_BITS = 4,
    parameter int DATA_W   = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  strobes_t            cur,
    input  strobes_t            fall,
    input  logic [ADDR_W-1:0]   addr_q,
    input  logic [DATA_W-1:0]   din_q,
    input  logic [DATA_W-1:0]   rd_data,
    output logic                wr_en,
    output logic [ROW_BITS-1:0] row_sel,
    output logic [COL_BITS-1:0] col_sel,
    output logic [DATA_W-1:0]   wr_data,
    output logic [DATA_W-1:0]   dout,
    output logic                drive,
    output cyc_e                cyc,
    output logic [ROW_BITS-1:0] ref_row
);

    logic [ROW_BITS-1:0] row_q;
    logic                first_col;
    logic                rd_valid;
    logic                both_high;
    logic                col_evt;

    // Event qualifiers shared by the write port and the state update.
    always_comb begin
        both_high = cur.ras && cur.cas;
        col_evt   = fall.cas && !cur.ras && !fall.ras &&
                    (cyc != CYC_CBR) && (cyc != CYC_IDLE);
        wr_en     = col_evt && !cur.we;
        row_sel   = row_q;
        col_sel   = addr_q[COL_BITS-1:0];
        wr_data   = din_q;
    end

    // Cycle state, row latch, refresh counter and output drive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc       <= CYC_IDLE;
            row_q     <= '0;
            ref_row   <= '0;
            first_col <= 1'b0;
            rd_valid  <= 1'b0;
            drive     <= 1'b0;
            dout      <= '0;
        end else if (both_high) begin
            cyc      <= CYC_IDLE;
            rd_valid <= 1'b0;
            drive    <= 1'b0;
        end else if (fall.ras) begin
            rd_valid <= 1'b0;
            drive    <= 1'b0;
            if (!cur.cas) begin
                cyc     <= CYC_CBR;
                ref_row <= ref_row + 1'b1;
            end else begin
                cyc       <= CYC_ROWOPEN;
                row_q     <= addr_q[ROW_BITS-1:0];
                first_col <= 1'b1;
            end
        end else if (col_evt) begin
            first_col <= 1'b0;
            if (!cur.we) begin
                cyc      <= first_col ? CYC_EWRITE : CYC_PAGE_WR;
                rd_valid <= 1'b0;
                drive    <= 1'b0;
            end else begin
                cyc      <= first_col ? CYC_READ : CYC_PAGE_RD;
                dout     <= rd_data;
                rd_valid <= 1'b1;
                drive    <= !cur.oe;
            end
        end else if (cur.oe) begin
            drive <= 1'b0;
        end else if (fall.we && rd_valid) begin
            rd_valid <= 1'b0;
            drive    <= 1'b0;
        end else if (fall.oe && rd_valid) begin
            drive <= 1'b1;
        end
    end

    // R1: both strobes high always leaves the bus released.
    assert_idle_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cur.ras && cur.cas) |=> (!drive && cyc == CYC_IDLE));

    // R3: a row fall under a low column strobe advances the refresh row by one.
    assert_refresh_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (fall.ras && !cur.cas) |=> (ref_row == ROW_BITS'($past(ref_row) + 1'b1)));

    // R3: the refresh counter moves only on a counter refresh.
    assert_refresh_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(fall.ras && !cur.cas) |=> $stable(ref_row));

    // R5: early-write accesses never drive the bus.
    assert_write_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc == CYC_EWRITE || cyc == CYC_PAGE_WR || cyc == CYC_CBR) |-> !drive);

    // R8: output enable high releases the bus on the next cycle.
    assert_oe_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cur.oe |=> !drive);

endmodule

// File: rtl/edo_dram_model.sv
// Module: edo_dram_model (top)
// Device-side EDO DRAM model: samples strobes, decodes cycles, stores bytes in
// a scaled array and reports cycle type, refresh row and timing violations.
// Assumes clk is much faster than the strobes; the data bus is split into
// dq_in, dq_out and dq_oe for a tri-state wrapper.
module edo_dram_model
    import edo_pkg::*;
#(
    parameter int ADDR_W        = 11,
    parameter int DATA_W        = 8,
    parameter int ROW_BITS      = 4,
    parameter int COL_BITS      = 4,
    parameter int MIN_RAS_LOW   = 4,
    parameter int MIN_PRECHARGE = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ras_n,
    input  logic                cas_n,
    input  logic                we_n,
    input  logic                oe_n,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   dq_in,
    output logic [DATA_W-1:0]   dq_out,
    output logic                dq_oe,
    output logic [2:0]          cycle_type,
    output logic [ROW_BITS-1:0] refresh_row,
    output logic                timing_viol
);

    strobes_t            pins, cur, fall, rise;
    logic [ADDR_W-1:0]   addr_q;
    logic [DATA_W-1:0]   din_q;
    logic                wr_en;
    logic [ROW_BITS-1:0] row_sel;
    logic [COL_BITS-1:0] col_sel;
    logic [DATA_W-1:0]   wr_data;
    logic [DATA_W-1:0]   rd_data;
    cyc_e                cyc;

    assign pins = '{ras: ras_n, cas: cas_n, we: we_n, oe: oe_n};

    edo_strobe_sampler #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_sampler (
        .clk(clk), .rst_n(rst_n), .pins(pins), .addr_pin(addr), .din_pin(dq_in),
        .cur(cur), .fall(fall), .rise(rise), .addr_q(addr_q), .din_q(din_q)
    );

    edo_cycle_ctrl #(.ADDR_W(ADDR_W), .ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS),
                     .DATA_W(DATA_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .cur(cur), .fall(fall), .addr_q(addr_q),
        .din_q(din_q), .rd_data(rd_data), .wr_en(wr_en), .row_sel(row_sel),
        .col_sel(col_sel), .wr_data(wr_data), .dout(dq_out), .drive(dq_oe),
        .cyc(cyc), .ref_row(refresh_row)
    );

    edo_cell_array #(.ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS), .DATA_W(DATA_W)) u_array (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_row(row_sel), .wr_col(col_sel),
        .wr_data(wr_data), .rd_row(row_sel), .rd_col(col_sel), .rd_data(rd_data)
    );

    edo_timing_mon #(.MIN_RAS_LOW(MIN_RAS_LOW), .MIN_PRECHARGE(MIN_PRECHARGE)) u_timing (
        .clk(clk), .rst_n(rst_n), .ras_low(!cur.ras), .ras_fall(fall.ras),
        .ras_rise(rise.ras), .viol(timing_viol)
    );

    assign cycle_type = cyc;

    // R3: the bus is never driven while a counter refresh is in progress.
    assert_refresh_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cycle_type == 3'd4) |-> !dq_oe);

    // R4: the bus is only driven in a read-type cycle.
    assert_drive_in_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> (cycle_type == 3'd1 || cycle_type == 3'd5));

endmodule

// File: tb/edo_dram_model_bench.sv
// Bench for edo_dram_model: directed corner cases plus seeded random
// single-access traffic checked against a mirror array kept in the bench.
module edo_dram_model_bench;

    localparam int CLK_PERIOD = 10;
    localparam int AW   = 11;
    localparam int DW   = 8;
    localparam int ROWB = 4;
    localparam int COLB = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [AW-1:0]   addr = '0;
    logic [DW-1:0]   dq_in = '0;
    logic [DW-1:0]   dq_out;
    logic            dq_oe;
    logic [2:0]      cycle_type;
    logic [ROWB-1:0] refresh_row;
    logic            timing_viol;

    int tests = 0;
    int fails = 0;
    int viol_cnt = 0;
    bit done = 1'b0;
    logic [DW-1:0] mirror [1 << (ROWB + COLB)];

    always #(CLK_PERIOD / 2) clk = ~clk;

    edo_dram_model u_edo_dram_model (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .oe_n(oe_n), .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe),
        .cycle_type(cycle_type), .refresh_row(refresh_row), .timing_viol(timing_viol)
    );

    // Count violation pulses away from the active edge.
    always @(negedge clk) if (rst_n && timing_viol) viol_cnt++;

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int idx(input int r, input int c);
        return r * (1 << COLB) + c;
    endfunction

    // Put a row or column on the bus with random upper bits (R2).
    task automatic put_addr(input int v);
        addr = AW'($urandom);
        addr[ROWB-1:0] = ROWB'(v);
    endtask

    task automatic open_row(input int r);
        put_addr(r);
        tick(1);
        ras_n = 1'b0;
        tick(2);
    endtask

    task automatic close_row();
        cas_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
        tick(2);
        ras_n = 1'b1;
        tick(4);
    endtask

    task automatic col_write(input int c, input logic [DW-1:0] d, input int r,
                             input int exp_type, input string req);
        put_addr(c);
        dq_in = d;
        we_n = 1'b0;
        oe_n = 1'b0;
        tick(1);
        cas_n = 1'b0;
        tick(3);
        mirror[idx(r, c)] = d;
        check(cycle_type == 3'(exp_type), req, cycle_type, exp_type);
        check(dq_oe == 1'b0, "R5 write keeps bus off", dq_oe, 0);
        cas_n = 1'b1;
        we_n = 1'b1;
        tick(3);
        check(dq_oe == 1'b0, "R5 bus off after write column", dq_oe, 0);
    endtask

    task automatic col_read(input int c, input int r, input int exp_type, input string req);
        put_addr(c);
        we_n = 1'b1;
        oe_n = 1'b0;
        tick(1);
        cas_n = 1'b0;
        tick(3);
        check(cycle_type == 3'(exp_type), req, cycle_type, exp_type);
        check(dq_oe == 1'b1 && dq_out == mirror[idx(r, c)], req,
              dq_oe ? int'(dq_out) : -1, int'(mirror[idx(r, c)]));
        cas_n = 1'b1;
        tick(3);
        check(dq_oe == 1'b1 && dq_out == mirror[idx(r, c)], "R7 data held after column rise",
              dq_oe ? int'(dq_out) : -1, int'(mirror[idx(r, c)]));
    endtask

    task automatic cbr_refresh(input int exp_row);
        cas_n = 1'b0;
        oe_n = 1'b0;
        tick(2);
        addr = AW'($urandom);
        ras_n = 1'b0;
        tick(5);
        check(cycle_type == 3'd4 && dq_oe == 1'b0, "R3 refresh type and bus off",
              {cycle_type, dq_oe}, 8);
        check(refresh_row == ROWB'(exp_row), "R3 refresh row", refresh_row, exp_row);
        ras_n = 1'b1;
        tick(1);
        cas_n = 1'b1;
        oe_n = 1'b1;
        tick(4);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin : main
        int refreshes;
        int vbase;
        void'($urandom(32'd20240611));
        for (int i = 0; i < (1 << (ROWB + COLB)); i++) mirror[i] = '0;
        tick(4);
        rst_n = 1'b1;
        tick(2);

        // R11: reset state.
        check(dq_oe == 1'b0, "R11 reset bus off", dq_oe, 0);
        check(cycle_type == 3'd0, "R11 reset idle type", cycle_type, 0);
        check(refresh_row == '0, "R11 reset refresh row", refresh_row, 0);
        check(timing_viol == 1'b0, "R11 reset no violation", timing_viol, 0);

        // R11 + R2: a never-written cell reads zero.
        open_row(9);
        check(cycle_type == 3'd3, "R2 row open type", cycle_type, 3);
        col_read(7, 9, 1, "R4 read of cleared cell");
        close_row();
        check(dq_oe == 1'b0 && cycle_type == 3'd0, "R1 both high releases bus",
              {cycle_type, dq_oe}, 0);

        // R5 then R4: early write with output enable low, then read back.
        open_row(3);
        col_write(5, 8'hA5, 3, 2, "R5 early write type");
        close_row();
        open_row(3);
        col_read(5, 3, 1, "R4 read back written byte");
        close_row();

        // R6: page mode writes and reads in one row.
        open_row(12);
        col_write(1, 8'h11, 12, 2, "R5 first column write type");
        col_write(2, 8'h22, 12, 6, "R6 page write type");
        col_write(15, 8'hF0, 12, 6, "R6 page write type");
        close_row();
        open_row(12);
        col_read(2, 12, 1, "R6 first page read");
        col_read(15, 12, 5, "R6 page read type and data");
        col_read(1, 12, 5, "R6 page read type and data");
        close_row();

        // R4/R8: output enable high at column fall, then OE-controlled drive.
        open_row(3);
        put_addr(5);
        oe_n = 1'b1;
        tick(1);
        cas_n = 1'b0;
        tick(3);
        check(dq_oe == 1'b0, "R4 no drive while output enable high", dq_oe, 0);
        oe_n = 1'b0;
        tick(3);
        check(dq_oe == 1'b1 && dq_out == 8'hA5, "R4 drive after output enable fall",
              dq_oe ? int'(dq_out) : -1, 8'hA5);
        oe_n = 1'b1;
        tick(3);
        check(dq_oe == 1'b0, "R8 output enable high releases bus", dq_oe, 0);
        oe_n = 1'b0;
        tick(3);
        check(dq_oe == 1'b1, "R4 drive restored on output enable fall", dq_oe, 1);
        // R8: write-enable pulse during read releases the bus.
        we_n = 1'b0;
        tick(2);
        we_n = 1'b1;
        tick(3);
        check(dq_oe == 1'b0, "R8 write-enable pulse releases bus", dq_oe, 0);
        close_row();
        open_row(3);
        col_read(5, 3, 1, "R8 cell unchanged by write-enable pulse");
        close_row();

        // R3: refresh counter, address ignored, wrap.
        refreshes = 0;
        for (int k = 0; k < 2; k++) begin
            refreshes++;
            cbr_refresh(refreshes % (1 << ROWB));
        end
        for (int k = 0; k < (1 << ROWB); k++) begin
            refreshes++;
            cbr_refresh(refreshes % (1 << ROWB));
        end
        check(refresh_row == ROWB'(2), "R3 refresh counter wrap", refresh_row, 2);
        open_row(3);
        col_read(5, 3, 1, "R3 refresh leaves data intact");
        close_row();

        // R9/R10: no violations so far on legal timing.
        check(viol_cnt == 0, "R9 R10 legal timing gives no pulse", viol_cnt, 0);
        vbase = viol_cnt;
        // R9: row low one sample short of the limit.
        ras_n = 1'b0;
        tick(3);
        ras_n = 1'b1;
        tick(5);
        check(viol_cnt == vbase + 1, "R9 short row-low flagged", viol_cnt, vbase + 1);
        // R9: exactly at the limit is legal.
        ras_n = 1'b0;
        tick(4);
        ras_n = 1'b1;
        tick(5);
        check(viol_cnt == vbase + 1, "R9 row-low at limit legal", viol_cnt, vbase + 1);
        // R10: precharge one sample short.
        ras_n = 1'b0;
        tick(6);
        ras_n = 1'b1;
        tick(2);
        ras_n = 1'b0;
        tick(6);
        ras_n = 1'b1;
        tick(5);
        check(viol_cnt == vbase + 2, "R10 short precharge flagged", viol_cnt, vbase + 2);
        // R10: precharge at the limit is legal.
        ras_n = 1'b0;
        tick(6);
        ras_n = 1'b1;
        tick(3);
        ras_n = 1'b0;
        tick(6);
        ras_n = 1'b1;
        tick(5);
        check(viol_cnt == vbase + 2, "R10 precharge at limit legal", viol_cnt, vbase + 2);

        // Random single accesses against the mirror (R2, R4, R5).
        for (int n = 0; n < 60; n++) begin
            int r;
            int c;
            r = int'($urandom_range((1 << ROWB) - 1, 0));
            c = int'($urandom_range((1 << COLB) - 1, 0));
            open_row(r);
            if ($urandom_range(1, 0) == 1)
                col_write(c, DW'($urandom), r, 2, "R5 random write type");
            else
                col_read(c, r, 1, "R2 random read data");
            close_row();
        end
        check(viol_cnt == vbase + 2, "R9 R10 random traffic legal", viol_cnt, vbase + 2);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule